// File: doc/BRIEF.md
# SPI Slave Link State Controller

This block is the link-level control for a slave on a shared SPI bus. After a local init-done strobe it moves through its operating states and drives the bus outputs each state allows. It releases MISO unless its own select is held. It shifts one word per selection in clock-polarity-0, phase-0 order. It can also raise a short access request towards the master.

Two variants are chosen by a parameter. In the 4-pin variant the slave requests an access by pulling its own open-drain select line low. In the 5-pin variant it pulses a dedicated interrupt output. Either request lasts a fixed window and then ends by itself. A request never overlaps a master selection. The 4-pin variant can also keep the select line low after a selection ends, which holds the master off (flow control). A sleep request parks the block in a low-power state, and master selection wakes it.

Top module: `spi_link_fsm`

## Requirements
- R1: After reset the state code is 0 (initial). MISO enable, interrupt and select pull are all 0. While init_done has not been seen, select and clock activity leave the state at 0 and produce no rx_valid.
- R2: An init_done pulse in state 0 moves the state to 1 (configured, de-selected).
- R3: spi_miso_en is 1 only in state 2 (selected). It is 0 in states 0, 1, 3, 4 and 5.
- R4: In state 1, a sensed low on spi_nss_in moves the state to 2. A sensed high in state 2 returns it to 1 when flow_hold is 0.
- R5: In state 2, MOSI is captured on each rising SPI clock edge, most significant bit first. After WORD_W rising edges, rx_word holds the word and rx_valid pulses for one cycle.
- R6: On entry to state 2, spi_miso carries bit WORD_W-1 of tx_word. Each falling SPI clock edge advances it to the next lower bit.
- R7: 5-pin variant: a tx_req taken in state 1 enters state 3 (pro-active). spi_irq is 1 for exactly REQ_CYCLES clock cycles, and then the state returns to 1 without master action.
- R8: 4-pin variant: a request drives spi_nss_pull to 1 for exactly REQ_CYCLES cycles. It starts only when the line is sensed high. spi_irq stays 0 throughout.
- R9: While the master holds select low, spi_irq and the request pull stay 0. A request made during a selection is kept pending and issued, with its full window, after the line is released.
- R10: 4-pin variant: if flow_hold is 1 when the selection ends, the state becomes 4 (busy) and spi_nss_pull stays 1 until flow_hold falls. The state then returns to 1. The 5-pin variant ignores flow_hold and returns to 1.
- R11: sleep_req in state 1 enters state 5 (power saving), with MISO released. A sensed select low in state 5 returns the state to 1, and from there to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_done | input | 1 | Local initialisation complete strobe |
| tx_req | input | 1 | Pulse: slave wants the master to access it |
| sleep_req | input | 1 | Pulse: enter power saving from de-selected |
| flow_hold | input | 1 | 4-pin only: keep select low after selection ends |
| spi_sclk | input | 1 | SPI clock pin (asynchronous) |
| spi_mosi | input | 1 | Master-out data pin |
| spi_nss_in | input | 1 | Sensed level of this slave's select line |
| tx_word | input | WORD_W | Word shifted out on MISO in each selection |
| spi_miso | output | 1 | Slave-out data |
| spi_miso_en | output | 1 | MISO output enable (0 = high impedance) |
| spi_nss_pull | output | 1 | Open-drain pull-down of the select line (4-pin) |
| spi_irq | output | 1 | Request interrupt line (5-pin) |
| rx_word | output | WORD_W | Last word received from MOSI |
| rx_valid | output | 1 | One-cycle strobe: rx_word updated |
| link_state | output | 3 | State code: 0 init, 1 de-selected, 2 selected, 3 pro-active, 4 busy, 5 power saving |

## Verification
Every pin passes SYNC_STAGES flops before the state machine sees it. A change on select or the SPI clock therefore shows in link_state and the shifter about SYNC_STAGES+1 cycles later. The bench waits six cycles after each select change and keeps each SPI clock half period at eight cycles, so every sample lands well after the result is due. Strobe inputs act on the next edge. The request window is measured exactly by counting, on falling system edges, the cycles in which spi_irq or spi_nss_pull is high. Received words go through a queue that a monitor drains on each rx_valid.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;

  typedef enum logic [2:0] {
    LS_INIT  = 3'd0,
    LS_IDLE  = 3'd1,
    LS_SEL   = 3'd2,
    LS_PRO   = 3'd3,
    LS_BUSY  = 3'd4,
    LS_SLEEP = 3'd5
  } link_state_e;

  // bits needed to count 0 .. n-1
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // cycles during which an own-driven select low may still echo through the synchroniser
  function automatic int echo_len(input int stages);
    return stages + 1;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_req_timer.sv
module spi_req_timer
  import spi_link_pkg::*;
#(
  parameter int CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = cnt_bits(CYCLES);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= run ? cnt + 1'b1 : '0;
  end

  assign done = run && (cnt == CW'(CYCLES - 1));

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(cnt) < CYCLES)); // R7
endmodule

// File: rtl/spi_mode0_shifter.sv
module spi_mode0_shifter
  import spi_link_pkg::*;
#(
  parameter int W = 8   // at least 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         sclk_s,
  input  logic         mosi_s,
  input  logic [W-1:0] tx_word,
  output logic         miso,
  output logic [W-1:0] rx_word,
  output logic         rx_valid
);
  localparam int BW = cnt_bits(W);

  logic          sclk_d;
  logic          rise, fall;
  logic [BW-1:0] bcnt;
  logic [W-1:0]  rx_sh, tx_sh;
  logic          reload;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      bcnt     <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
      reload   <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      rx_valid <= 1'b0;
      if (!active) begin
        bcnt   <= '0;
        tx_sh  <= tx_word;
        reload <= 1'b0;
      end else begin
        if (rise) begin
          rx_sh <= {rx_sh[W-2:0], mosi_s};
          if (bcnt == BW'(W - 1)) begin
            bcnt     <= '0;
            rx_word  <= {rx_sh[W-2:0], mosi_s};
            rx_valid <= 1'b1;
            reload   <= 1'b1;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        if (fall) begin
          if (reload) begin
            tx_sh  <= tx_word;
            reload <= 1'b0;
          end else begin
            tx_sh <= {tx_sh[W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso = tx_sh[W-1];

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bcnt) < W); // R5
endmodule

// File: rtl/spi_link_fsm.sv
module spi_link_fsm
  import spi_link_pkg::*;
#(
  parameter int LINK_PINS   = 4,   // 4: request on select line, 5: dedicated interrupt
  parameter int REQ_CYCLES  = 50,  // request window in clk cycles
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              tx_req,
  input  logic              sleep_req,
  input  logic              flow_hold,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_nss_in,
  input  logic [WORD_W-1:0] tx_word,
  output logic              spi_miso,
  output logic              spi_miso_en,
  output logic              spi_nss_pull,
  output logic              spi_irq,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic [2:0]        link_state
);
  localparam bit HAS_INT  = (LINK_PINS == 5);
  localparam int ECHO_LEN = echo_len(SYNC_STAGES);
  localparam int EW       = cnt_bits(ECHO_LEN + 1);

  // synchronised pins
  logic sclk_s, mosi_s, nss_s;
  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({spi_sclk, spi_mosi, spi_nss_in}),
    .q    ({sclk_s, mosi_s, nss_s})
  );

  link_state_e   st, st_nx;
  logic          pend;
  logic [EW-1:0] echo_q;

  // named internal events
  logic line_idle;      // select sensed high and not our own echo
  logic master_sel;     // master selection seen
  logic req_launch;     // entering pro-active
  logic req_done;       // request window over
  logic own_release;    // 4-pin: we stop pulling the line

  assign line_idle  = nss_s && (echo_q == '0);
  assign master_sel = !nss_s && (echo_q == '0);

  spi_req_timer #(.CYCLES(REQ_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st == LS_PRO),
    .done (req_done)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      LS_INIT:  if (init_done) st_nx = LS_IDLE;
      LS_IDLE: begin
        if (master_sel)             st_nx = LS_SEL;
        else if (sleep_req)         st_nx = LS_SLEEP;
        else if (pend && line_idle) st_nx = LS_PRO;
      end
      LS_SEL:   if (nss_s) st_nx = (!HAS_INT && flow_hold) ? LS_BUSY : LS_IDLE;
      LS_PRO: begin
        if (HAS_INT && !nss_s) st_nx = LS_SEL;
        else if (req_done)     st_nx = LS_IDLE;
      end
      LS_BUSY:  if (!flow_hold) st_nx = LS_IDLE;
      LS_SLEEP: if (!nss_s) st_nx = LS_IDLE;
      default:  st_nx = LS_IDLE;
    endcase
  end

  assign req_launch  = (st == LS_IDLE) && (st_nx == LS_PRO);
  assign own_release = !HAS_INT && (st == LS_PRO || st == LS_BUSY) && (st_nx == LS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= LS_INIT;
      pend   <= 1'b0;
      echo_q <= '0;
    end else begin
      st <= st_nx;
      if (st == LS_INIT)   pend <= 1'b0;
      else if (tx_req)     pend <= 1'b1;
      else if (req_launch) pend <= 1'b0;
      if (own_release)         echo_q <= EW'(ECHO_LEN);
      else if (echo_q != '0)   echo_q <= echo_q - 1'b1;
    end
  end

  // bus drive per variant
  generate
    if (HAS_INT) begin : g_five
      assign spi_irq      = (st == LS_PRO) && nss_s;
      assign spi_nss_pull = 1'b0;
    end else begin : g_four
      assign spi_irq      = 1'b0;
      assign spi_nss_pull = (st == LS_PRO) || (st == LS_BUSY);
    end
  endgenerate

  assign spi_miso_en = (st == LS_SEL);
  assign link_state  = st;

  spi_mode0_shifter #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (st == LS_SEL),
    .sclk_s  (sclk_s),
    .mosi_s  (mosi_s),
    .tx_word (tx_word),
    .miso    (spi_miso),
    .rx_word (rx_word),
    .rx_valid(rx_valid)
  );

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_INIT) |-> (!spi_miso_en && !spi_irq && !spi_nss_pull)); // R1
  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_INIT && !init_done) |=> (st == LS_INIT)); // R1
  AST_RX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(st) == LS_SEL)); // R5
  AST_PRO_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_PRO && req_done) |=> (st != LS_PRO)); // R7
  AST_PULL_ON_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_nss_pull) && st == LS_PRO) |-> $past(nss_s)); // R8
  AST_IRQ_NSS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    spi_irq |-> $past(nss_s)); // R9
  AST_SLEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_SLEEP && !nss_s) |=> (st == LS_IDLE)); // R11
endmodule

// File: tb/spi_link_fsm_test.sv
module spi_link_fsm_test;
  localparam int REQ  = 50;
  localparam int W    = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic rst_n = 1'b0;
  logic init_done = 0, tx_req5 = 0, tx_req4 = 0, sleep_req = 0, flow_hold = 0;
  logic sclk = 0, mosi = 0, nss5 = 1, nss4m = 1;
  logic [W-1:0] tx_word = '0;

  logic miso5, oe5, pull5, irq5, rxv5;
  logic miso4, oe4, pull4, irq4, rxv4;
  logic [W-1:0] rx5, rx4;
  logic [2:0] st5, st4;
  logic nss4_line;
  assign nss4_line = nss4m & ~pull4;   // open-drain line

  spi_link_fsm #(.LINK_PINS(5), .REQ_CYCLES(REQ), .WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .tx_req(tx_req5),
    .sleep_req(sleep_req), .flow_hold(flow_hold), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_nss_in(nss5), .tx_word(tx_word),
    .spi_miso(miso5), .spi_miso_en(oe5), .spi_nss_pull(pull5), .spi_irq(irq5),
    .rx_word(rx5), .rx_valid(rxv5), .link_state(st5));

  spi_link_fsm #(.LINK_PINS(4), .REQ_CYCLES(REQ), .WORD_W(W)) uut4 (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .tx_req(tx_req4),
    .sleep_req(sleep_req), .flow_hold(flow_hold), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_nss_in(nss4_line), .tx_word(tx_word),
    .spi_miso(miso4), .spi_miso_en(oe4), .spi_nss_pull(pull4), .spi_irq(irq4),
    .rx_word(rx4), .rx_valid(rxv4), .link_state(st4));

  int checks = 0, errors = 0;
  int irq_viol = 0, irq4_hits = 0, pull5_hits = 0;
  logic [W-1:0] q5[$], q4[$];
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rxv5) begin
        if (q5.size() == 0) chk("R5 unexpected rx (5-pin)", int'(rx5), -1);
        else chk("R5 rx word (5-pin)", int'(rx5), int'(q5.pop_front()));
      end
      if (rxv4) begin
        if (q4.size() == 0) chk("R5 unexpected rx (4-pin)", int'(rx4), -1);
        else chk("R5 rx word (4-pin)", int'(rx4), int'(q4.pop_front()));
      end
      if (irq5 && !nss5) irq_viol++;
      if (irq4) irq4_hits++;
      if (pull5) pull5_hits++;
    end
  end

  // driver: one word, expectation pushed to the target queue
  task automatic spi_xfer(input bit four, input logic [W-1:0] mw, input logic [W-1:0] sw);
    tx_word = sw;
    if (four) begin nss4m = 0; q4.push_back(mw); end
    else      begin nss5  = 0; q5.push_back(mw); end
    cyc(6);
    chk("R4 selected state", int'(four ? st4 : st5), 2);
    chk("R3 miso enabled when selected", int'(four ? oe4 : oe5), 1);
    for (int i = W - 1; i >= 0; i--) begin
      mosi = mw[i];
      cyc(HALF);
      chk("R6 miso bit", int'(four ? miso4 : miso5), int'(sw[i]));
      sclk = 1;
      cyc(HALF);
      sclk = 0;
    end
    cyc(HALF);
    if (four) nss4m = 1; else nss5 = 1;
    cyc(6);
    chk("R4 de-selected state", int'(four ? st4 : st5), 1);
    chk("R3 miso released", int'(four ? oe4 : oe5), 0);
  endtask

  task automatic measure(input bit four, input int n, output int w);
    w = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (four ? pull4 : irq5) w++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int w;
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1: reset state
    chk("R1 state 5-pin", int'(st5), 0);
    chk("R1 state 4-pin", int'(st4), 0);
    chk("R1 miso enable", int'(oe5 | oe4), 0);
    chk("R1 irq/pull", int'(irq5 | pull4), 0);
    // R1: activity before init is ignored
    nss5 = 0; nss4m = 0;
    for (int i = 0; i < 2 * W; i++) begin cyc(HALF); sclk = ~sclk; end
    cyc(6);
    chk("R1 no move before init", int'(st5), 0);
    chk("R1 no move before init (4-pin)", int'(st4), 0);
    chk("R1 miso stays released", int'(oe5 | oe4), 0);
    nss5 = 1; nss4m = 1; sclk = 0;
    cyc(6);
    // R2
    init_done = 1; cyc(1); init_done = 0;
    cyc(1);
    chk("R2 de-selected after init", int'(st5), 1);
    chk("R2 de-selected after init (4-pin)", int'(st4), 1);
    chk("R3 miso released when de-selected", int'(oe5), 0);
    // R4/R5/R6 transfers
    spi_xfer(0, 8'hA5, 8'h3C);
    spi_xfer(0, 8'h00, 8'hFF);
    spi_xfer(1, 8'h96, 8'h81);
    spi_xfer(1, 8'hFF, 8'h5A);
    // R7: 5-pin request window
    tx_req5 = 1; cyc(1); tx_req5 = 0;
    cyc(1);
    chk("R7 pro-active state", int'(st5), 3);
    chk("R3 miso released in pro-active", int'(oe5), 0);
    measure(0, 300, w);
    chk("R7 irq window width", w + 1, REQ);
    chk("R7 back to de-selected", int'(st5), 1);
    chk("R7 select never pulled (5-pin)", pull5_hits, 0);
    // R8: 4-pin request window
    tx_req4 = 1; cyc(1); tx_req4 = 0;
    measure(1, 300, w);
    chk("R8 pull window width", w, REQ);
    chk("R8 no irq in 4-pin", irq4_hits, 0);
    cyc(6);
    chk("R8 back to de-selected", int'(st4), 1);
    // R9: 5-pin request during selection
    nss5 = 0; cyc(6);
    tx_req5 = 1; cyc(1); tx_req5 = 0;
    measure(0, 100, w);
    chk("R9 irq held off while selected", w, 0);
    nss5 = 1;
    measure(0, 300, w);
    chk("R9 deferred irq window", w, REQ);
    chk("R9 irq never with select low", irq_viol, 0);
    // R9: 4-pin request during selection
    nss4m = 0; cyc(6);
    tx_req4 = 1; cyc(1); tx_req4 = 0;
    measure(1, 100, w);
    chk("R9 pull held off while selected", w, 0);
    nss4m = 1;
    measure(1, 300, w);
    chk("R9 deferred pull window", w, REQ);
    cyc(6);
    // R10: flow control
    flow_hold = 1;
    nss4m = 0; nss5 = 0; cyc(6);
    nss4m = 1; nss5 = 1; cyc(6);
    chk("R10 busy state", int'(st4), 4);
    chk("R10 select held low", int'(pull4), 1);
    chk("R10 5-pin ignores hold", int'(st5), 1);
    chk("R3 miso released in busy", int'(oe4), 0);
    flow_hold = 0; cyc(6);
    chk("R10 busy exit", int'(st4), 1);
    chk("R10 pull released", int'(pull4), 0);
    // R11: power saving
    sleep_req = 1; cyc(1); sleep_req = 0;
    cyc(1);
    chk("R11 sleep state", int'(st5), 5);
    chk("R11 sleep state (4-pin)", int'(st4), 5);
    chk("R11 miso released in sleep", int'(oe5), 0);
    nss5 = 0; cyc(8);
    chk("R11 wake to selected", int'(st5), 2);
    chk("R11 other slave stays asleep", int'(st4), 5);
    nss5 = 1; nss4m = 0; cyc(8);
    nss4m = 1; cyc(8);
    chk("R11 4-pin woke and de-selected", int'(st4), 1);
    chk("R5 scoreboard drained", q5.size() + q4.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule